// File: doc/BRIEF.md
# Retention-Binned Row Refresh Controller

This block walks every row of a memory array once per base refresh period and issues a refresh command for a row only when that row's retention class makes it due. Two Bloom filters hold the row sets of the two short-retention classes. The fast class covers rows that keep data for 64 to 128 ms, and the mid class covers rows that keep data for 128 to 256 ms. A row that neither filter reports falls into the slow default class. Each filter may report a row that was never inserted, which only makes that row refresh more often than it needs. An inserted row is never missed, so no row is refreshed too rarely.

Profiled rows are written in through an insert port that selects the target filter. A clear input empties both filters. Three counters drive the refresh walk:

- a pace counter, which gives each row a slot of fixed length;
- a row counter, which sweeps the address space;
- a two-bit period counter, which picks the classes that are due in the current sweep.

Commands leave on a valid/ready port that carries the row address. A stalled port freezes the walk.

Top module: `retention_refresh_ctrl`

## Requirements
- R1: While reset is low and right after it is released, `ref_row_o` is 0, the period index is 0 and `ref_valid_o` is 1, because with empty filters row 0 is due in period 0. Both filters are empty after reset.
- R2: Rows are visited in increasing order and wrap from the last row to row 0. Each wrap increments a 2-bit period index. Without a stall, each row occupies exactly STEP cycles.
- R3: For hash j (0 to NUM_HASH-1), take the row address rotated left by j bit positions. Output bit b of the hash is the XOR of every bit i of that rotated value with i mod FILT_W equal to b. An insert sets the filter bits selected by all NUM_HASH hashes. A row tests present when all of its hashed bits are set.
- R4: A row inserted into a filter is always treated as a member of that filter until the next clear, so it never refreshes less often than its class requires.
- R5: A row that the fast filter (`ins_bin_i`=0) reports present is refreshed in every period.
- R6: A row that the mid filter (`ins_bin_i`=1) reports present and the fast filter does not is refreshed only in periods whose index is even.
- R7: A row in neither filter is refreshed only in periods whose index is 0.
- R8: A row that is not due raises no command. Its slot still lasts STEP cycles.
- R9: While a command is valid and not accepted, `ref_valid_o` stays high, `ref_row_o` stays stable and the walk does not advance. Each row gets at most one accepted command per period. After acceptance at or past the end of the slot, the next row appears in the following cycle.
- R10: A clear empties both filters from the next cycle onward. Clear takes priority over a simultaneous insert.
- R11: An insert only sets bits and never removes one. It affects membership tests from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Empty both filters |
| ins_valid_i | input | 1 | Insert a profiled row |
| ins_bin_i | input | 1 | Target filter: 0 selects fast, 1 selects mid |
| ins_row_i | input | ROW_W | Row address to insert |
| ref_valid_o | output | 1 | Refresh command valid |
| ref_ready_i | input | 1 | Refresh command accepted |
| ref_row_o | output | ROW_W | Row address to refresh |

## Verification
The bench builds the block with ROW_W=4, FILT_W=3, NUM_HASH=2 and STEP=3. That gives 16 rows, 8-bit filters and three-cycle slots. At this size the bench can compute every hash and every false positive arithmetically and compare all slots of nine full sweeps cycle by cycle. The nine sweeps cover every period phase, including the phases before and after a clear. A stall that outlasts a slot and a clear issued during a stall both fit inside those sweeps.

// File: rtl/rr_refresh_pkg.sv
package rr_refresh_pkg;

  // Rotate row left by rot, then XOR-fold bit i into index bit (i mod filt_w).
  function automatic int fold_idx(input logic [31:0] row, input int row_w,
                                  input int filt_w, input int rot);
    int idx;
    int src;
    idx = 0;
    for (int i = 0; i < 32; i++) begin
      if (i < row_w) begin
        src = (i + row_w - (rot % row_w)) % row_w;
        if (row[src]) idx = idx ^ (1 << (i % filt_w));
      end
    end
    return idx;
  endfunction

endpackage

// File: rtl/rr_bloom_filter.sv
module rr_bloom_filter #(
  parameter int ROW_W    = 14,
  parameter int FILT_W   = 10,
  parameter int NUM_HASH = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clear_i,
  input  logic                   ins_i,
  input  logic [ROW_W-1:0]       ins_row_i,
  input  logic [ROW_W-1:0]       probe_row_i,
  output logic                   hit_o,
  output logic [(1<<FILT_W)-1:0] bits_o
);
  localparam int NBITS = 1 << FILT_W;

  logic [FILT_W-1:0] ins_idx   [NUM_HASH];
  logic [FILT_W-1:0] probe_idx [NUM_HASH];
  logic [NBITS-1:0]  bits_q;
  logic [NBITS-1:0]  set_mask;

  for (genvar j = 0; j < NUM_HASH; j++) begin : g_hash
    assign ins_idx[j]   = FILT_W'(rr_refresh_pkg::fold_idx(32'(ins_row_i), ROW_W, FILT_W, j));
    assign probe_idx[j] = FILT_W'(rr_refresh_pkg::fold_idx(32'(probe_row_i), ROW_W, FILT_W, j));
  end

  always_comb begin
    set_mask = '0;
    for (int j = 0; j < NUM_HASH; j++) set_mask[ins_idx[j]] = 1'b1;
  end

  always_comb begin
    hit_o = 1'b1;
    for (int j = 0; j < NUM_HASH; j++) hit_o = hit_o & bits_q[probe_idx[j]];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      bits_q <= '0;
    else if (clear_i) bits_q <= '0;
    else if (ins_i)   bits_q <= bits_q | set_mask;
  end

  assign bits_o = bits_q;
endmodule

// File: rtl/rr_refresh_walker.sv
module rr_refresh_walker #(
  parameter int ROW_W = 14,
  parameter int STEP  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_fast_i,
  input  logic             hit_mid_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int PACE_W = (STEP > 1) ? $clog2(STEP) : 1;
  localparam logic [PACE_W-1:0] PACE_LAST = PACE_W'(STEP - 1);
  localparam logic [ROW_W-1:0]  ROW_LAST  = '1;

  logic [ROW_W-1:0]  row_q;
  logic [1:0]        period_q;
  logic [PACE_W-1:0] pace_q;
  logic              sent_q;
  logic              due, fire, slot_end, advance;

  always_comb begin
    if (hit_fast_i)     due = 1'b1;
    else if (hit_mid_i) due = ~period_q[0];
    else                due = (period_q == 2'd0);
  end

  assign valid_o  = due & ~sent_q;
  assign fire     = valid_o & ready_i;
  assign slot_end = (pace_q == PACE_LAST);
  assign advance  = slot_end & (~due | sent_q | fire);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q    <= '0;
      period_q <= '0;
      pace_q   <= '0;
      sent_q   <= 1'b0;
    end else if (advance) begin
      pace_q <= '0;
      sent_q <= 1'b0;
      row_q  <= row_q + 1'b1;
      if (row_q == ROW_LAST) period_q <= period_q + 1'b1;
    end else begin
      if (!slot_end) pace_q <= pace_q + 1'b1;
      if (fire)      sent_q <= 1'b1;
    end
  end

  assign row_o = row_q;
endmodule

// File: rtl/retention_refresh_ctrl.sv
module retention_refresh_ctrl #(
  parameter int ROW_W    = 14,
  parameter int FILT_W   = 10,
  parameter int NUM_HASH = 3,
  parameter int STEP     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             ins_valid_i,
  input  logic             ins_bin_i,
  input  logic [ROW_W-1:0] ins_row_i,
  output logic             ref_valid_o,
  input  logic             ref_ready_i,
  output logic [ROW_W-1:0] ref_row_o
);
  localparam int NBITS  = 1 << FILT_W;
  localparam int N_FILT = 2;

  logic [ROW_W-1:0] cur_row;
  logic [N_FILT-1:0] hit;
  logic [NBITS-1:0] filt_bits [N_FILT];
  logic [NBITS-1:0] fast_bits, mid_bits;

  for (genvar g = 0; g < N_FILT; g++) begin : g_bin
    localparam logic SEL = 1'(g);
    rr_bloom_filter #(.ROW_W(ROW_W), .FILT_W(FILT_W), .NUM_HASH(NUM_HASH)) u_filt (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clear_i     (clear_i),
      .ins_i       (ins_valid_i && (ins_bin_i == SEL)),
      .ins_row_i   (ins_row_i),
      .probe_row_i (cur_row),
      .hit_o       (hit[g]),
      .bits_o      (filt_bits[g])
    );
  end

  assign fast_bits = filt_bits[0];
  assign mid_bits  = filt_bits[1];

  rr_refresh_walker #(.ROW_W(ROW_W), .STEP(STEP)) u_walk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_fast_i (hit[0]),
    .hit_mid_i  (hit[1]),
    .ready_i    (ref_ready_i),
    .valid_o    (ref_valid_o),
    .row_o      (cur_row)
  );

  assign ref_row_o = cur_row;
endmodule

// File: rtl/retention_refresh_checker.sv
module retention_refresh_checker #(
  parameter int ROW_W = 14,
  parameter int NBITS = 1024
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clear_i,
  input logic             ins_valid_i,
  input logic             ref_valid_o,
  input logic             ref_ready_i,
  input logic [ROW_W-1:0] ref_row_o,
  input logic [NBITS-1:0] fast_bits_i,
  input logic [NBITS-1:0] mid_bits_i
);
  assert_stall_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_valid_o && !ref_ready_i && !clear_i && !ins_valid_i) |=> (ref_valid_o && $stable(ref_row_o)));

  assert_one_cmd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_valid_o && ref_ready_i) |=> (!ref_valid_o || (ref_row_o != $past(ref_row_o))));

  assert_row_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_row_o != $past(ref_row_o)) |-> (ref_row_o == ROW_W'($past(ref_row_o) + 1'b1)));

  assert_clear_empty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> ((fast_bits_i == '0) && (mid_bits_i == '0)));

  assert_fast_monotone_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> ((fast_bits_i & $past(fast_bits_i)) == $past(fast_bits_i)));

  assert_mid_monotone_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> ((mid_bits_i & $past(mid_bits_i)) == $past(mid_bits_i)));
endmodule

bind retention_refresh_ctrl retention_refresh_checker #(.ROW_W(ROW_W), .NBITS(1 << FILT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clear_i     (clear_i),
  .ins_valid_i (ins_valid_i),
  .ref_valid_o (ref_valid_o),
  .ref_ready_i (ref_ready_i),
  .ref_row_o   (ref_row_o),
  .fast_bits_i (fast_bits),
  .mid_bits_i  (mid_bits)
);

// File: tb/sim_retention_refresh_ctrl.sv
`timescale 1ns/1ps
module sim_retention_refresh_ctrl;
  localparam int ROW_W = 4, FILT_W = 3, NUM_HASH = 2, STEP = 3;
  localparam int NROWS = 1 << ROW_W, NB = 1 << FILT_W;

  logic clk = 1'b0, rst_ni = 1'b0, clear_i = 1'b0, ins_valid_i = 1'b0, ins_bin_i = 1'b0;
  logic ref_ready_i = 1'b1;
  logic [ROW_W-1:0] ins_row_i = '0;
  logic ref_valid_o;
  logic [ROW_W-1:0] ref_row_o;

  int checks = 0, fails = 0;
  bit finished = 0;
  bit sh [2][NB];
  bit inserted [NROWS];
  int exp_row = 0, exp_per = 0;

  always #2.5 clk = ~clk;

  retention_refresh_ctrl #(.ROW_W(ROW_W), .FILT_W(FILT_W), .NUM_HASH(NUM_HASH), .STEP(STEP)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear_i), .ins_valid_i(ins_valid_i),
    .ins_bin_i(ins_bin_i), .ins_row_i(ins_row_i), .ref_valid_o(ref_valid_o),
    .ref_ready_i(ref_ready_i), .ref_row_o(ref_row_o));

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (row %0d period %0d)", req, act, expv, exp_row, exp_per);
    end
  endtask

  // R3 hash: rotate left by j, bit i lands on index bit i % FILT_W
  function automatic int bhash(int row, int j);
    int idx = 0;
    for (int i = 0; i < ROW_W; i++) begin
      int src = (i - j + ROW_W) % ROW_W;
      if (((row >> src) & 1) != 0) idx = idx ^ (1 << (i % FILT_W));
    end
    return idx;
  endfunction

  function automatic bit member(int f, int row);
    bit m = 1;
    for (int j = 0; j < NUM_HASH; j++) m = m & sh[f][bhash(row, j)];
    return m;
  endfunction

  function automatic bit is_due(int row, int per);
    if (member(0, row)) return 1;
    if (member(1, row)) return (per % 2) == 0;
    return (per % 4) == 0;
  endfunction

  function automatic string req_of(int row, int per, int aper);
    if (!is_due(row, per)) return (aper >= 4) ? "R8/R10" : "R8";
    if (inserted[row]) return "R4";
    if (member(0, row)) return "R5";
    if (member(1, row)) return "R6";
    return "R7";
  endfunction

  task automatic do_slot(int first_c, int hold, int clr_at, int aper);
    bit due, sent, done;
    int c;
    string rq;
    due  = is_due(exp_row, exp_per);
    rq   = req_of(exp_row, exp_per, aper);
    sent = 0;
    c    = first_c;
    forever begin
      chk(ref_row_o == ROW_W'(exp_row), "R2", int'(ref_row_o), exp_row);
      if (due && !sent) begin
        chk(ref_valid_o == 1'b1, (c - first_c > 0) ? "R9" : rq, int'(ref_valid_o), 1);
        ref_ready_i = ((c - first_c) >= hold);
        if (ref_ready_i) sent = 1;
      end else begin
        chk(ref_valid_o == 1'b0, (sent ? "R9" : rq), int'(ref_valid_o), 0);
        ref_ready_i = 1'b1;
      end
      clear_i = ((c - first_c) == clr_at);
      done = (c >= STEP - 1) && (!due || sent);
      @(posedge clk);
      @(negedge clk);
      if (clear_i) begin
        for (int b = 0; b < NB; b++) begin sh[0][b] = 0; sh[1][b] = 0; end
        for (int r = 0; r < NROWS; r++) inserted[r] = 0;
      end
      clear_i = 1'b0;
      c++;
      if (done) break;
    end
    ref_ready_i = 1'b1;
    exp_row = (exp_row + 1) % NROWS;
    if (exp_row == 0) exp_per = (exp_per + 1) % 4;
  endtask

  task automatic ins(int row, int f);
    ins_valid_i = 1'b1; ins_bin_i = f[0]; ins_row_i = ROW_W'(row);
    @(negedge clk);
    ins_valid_i = 1'b0;
    for (int j = 0; j < NUM_HASH; j++) sh[f][bhash(row, j)] = 1;
    inserted[row] = 1;
    // walk stalled on row 0 during inserts
    chk(ref_valid_o == 1'b1 && ref_row_o == '0, "R9", int'(ref_row_o), 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    int aper;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ref_row_o == '0, "R1", int'(ref_row_o), 0);
    chk(ref_valid_o == 1'b1, "R1", int'(ref_valid_o), 1);
    rst_ni = 1'b1;
    ref_ready_i = 1'b0;
    @(negedge clk);
    chk(ref_row_o == '0 && ref_valid_o, "R1", int'(ref_row_o), 0);
    ins(3, 0); ins(9, 0); ins(5, 1); ins(12, 1);   // R11: effective for the walk below
    @(negedge clk);
    do_slot(STEP - 1, 0, -1, 0);
    aper = 0;
    while (aper < 9) begin
      int hold = 0, clr = -1;
      if (aper == 2 && exp_row == 3) hold = 5;                      // R9 stall past slot end
      if (aper == 4 && exp_row == 0) begin hold = 3; clr = 1; end   // R10 clear during stall
      do_slot(0, hold, clr, aper);
      if (exp_row == 0) aper++;
    end
    summary();
    finished = 1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end
endmodule